// File: doc/BRIEF.md
# Serial Audio Transmit/Receive FIFO with Sticky Error Flags

This block buffers audio words between a host register port and a serial shifter. The host writes words into a transmit queue. The shifter takes them one at a time by raising a load request. The shifter pushes received words into a receive queue, and the host drains that queue through a read strobe. Each queue reports full, empty and an occupancy count.

Three misuse events are latched in a status vector. Bit 2 is transmit overflow, bit 1 is transmit underflow and bit 0 is receive underflow. A flag stays set until the host writes 1 to its bit. When the shifter asks for a word and the transmit queue is empty, the word it last received is held on its data port, so it keeps sending that word again. Each direction has its own enable. A low enable empties that direction's queue and stops that direction's flags from being raised.

Top module: `audio_fifo_ctrl`

## Requirements
- R1: Each queue holds up to DEPTH words (default 16). The count output gives the occupancy. Full is high exactly when the count equals DEPTH, and empty is high exactly when the count is zero. After reset both counts are zero, all flags are zero and `shf_tx_data` is zero.
- R2: Words leave in the order they entered. One cycle after an accepted `shf_load`, `shf_tx_data` shows the oldest transmit word. While the receive queue is not empty, `host_rx_data` shows the oldest receive word.
- R3: When `host_tx_wr` is asserted while the transmit queue is full and `tx_en` is 1, status bit 2 is set. The written word is dropped, and the queue contents and count stay unchanged.
- R4: When `shf_load` is asserted while the transmit queue is empty and `tx_en` is 1, status bit 1 is set. `shf_tx_data` keeps the word it held before.
- R5: When `host_rx_rd` is asserted while the receive queue is empty and `rx_en` is 1, status bit 0 is set. The data returned is unspecified.
- R6: No event sets bit 2 or bit 1 while `tx_en` is 0, and no event sets bit 0 while `rx_en` is 0.
- R7: A set flag stays set in every cycle in which its bit is not cleared. Writing 0 to a bit through `host_stat_wr` has no effect.
- R8: Writing 1 to a status bit through `host_stat_wr` clears that bit in the next cycle. If an error event for the same bit happens in the same cycle, the bit stays set.
- R9: While `tx_en` is 0, the transmit queue is emptied, its writes and loads are ignored, and `shf_tx_data` becomes 0. While `rx_en` is 0, the receive queue is emptied and its pushes and reads are ignored.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full both take effect, and the count stays the same.
- R11: A `shf_rx_push` while the receive queue is full is dropped. The queue is unchanged and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| host_tx_wr | input | 1 | Host write strobe for the transmit queue |
| host_tx_data | input | W | Word written by the host |
| host_rx_rd | input | 1 | Host read strobe that pops the receive queue |
| host_rx_data | output | W | Oldest receive word |
| host_stat_wr | input | 1 | Write strobe for the status vector; a 1 in a bit clears that flag |
| host_stat_wdata | input | 3 | Clear mask (bit2 tx overflow, bit1 tx underflow, bit0 rx underflow) |
| stat_flags | output | 3 | Sticky flags, same bit order as the mask |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_count | output | $clog2(DEPTH+1) | Transmit occupancy |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_count | output | $clog2(DEPTH+1) | Receive occupancy |
| shf_load | input | 1 | Shifter load request, pops the transmit queue |
| shf_tx_data | output | W | Word most recently handed to the shifter |
| shf_rx_push | input | 1 | Shifter strobe that pushes a received word |
| shf_rx_data | input | W | Received word |

## Verification
The bench builds the block with DEPTH = 4 and W = 32. The shallow queue lets biased random traffic reach the full boundary often, so overflow, dropped receive pushes and push-with-pop on a full queue occur many times per run. The same traffic also drains the queues to empty, which produces repeated underflows and the held shifter word. Toggling the enables and writing random clear masks exercises flushing, gating and the clear-versus-event priority at that same depth.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef struct packed {
        logic tx_ovf;
        logic tx_udf;
        logic rx_udf;
    } err_flags_t;

    localparam int FLAG_W = $bits(err_flags_t);

    function automatic err_flags_t flag_update(err_flags_t cur, err_flags_t clr, err_flags_t ev);
        return err_flags_t'((cur & ~clr) | ev);
    endfunction

endpackage

// File: rtl/sfifo_queue.sv
module sfifo_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R3
    push_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (count == CW'(DEPTH)));

    // R10
    push_pop_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !full && !empty && !flush) |=> $stable(count));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/sfifo_err_flags.sv
module sfifo_err_flags
    import sfifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  err_flags_t ev,
    input  logic       clr_we,
    input  err_flags_t clr_mask,
    output err_flags_t flags
);

    err_flags_t clr_eff;
    err_flags_t keep;

    assign clr_eff = clr_we ? clr_mask : err_flags_t'('0);
    assign keep    = err_flags_t'(flags & ~clr_eff);

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= flag_update(flags, clr_eff, ev);
    end

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(keep)) == $past(keep)));

    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(ev)) == $past(ev)));

endmodule

// File: rtl/audio_fifo_ctrl.sv
module audio_fifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              host_tx_wr,
    input  logic [W-1:0]      host_tx_data,
    input  logic              host_rx_rd,
    output logic [W-1:0]      host_rx_data,
    input  logic              host_stat_wr,
    input  logic [FLAG_W-1:0] host_stat_wdata,
    output logic [FLAG_W-1:0] stat_flags,
    output logic              tx_full,
    output logic              tx_empty,
    output logic [CW-1:0]     tx_count,
    output logic              rx_full,
    output logic              rx_empty,
    output logic [CW-1:0]     rx_count,
    input  logic              shf_load,
    output logic [W-1:0]      shf_tx_data,
    input  logic              shf_rx_push,
    input  logic [W-1:0]      shf_rx_data
);

    logic [W-1:0] tx_head;
    logic [W-1:0] last_word;
    err_flags_t   ev;
    err_flags_t   flags_q;

    sfifo_queue #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(!tx_en),
        .push(host_tx_wr), .din(host_tx_data),
        .pop(shf_load), .dout(tx_head),
        .full(tx_full), .empty(tx_empty), .count(tx_count)
    );

    sfifo_queue #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(!rx_en),
        .push(shf_rx_push), .din(shf_rx_data),
        .pop(host_rx_rd), .dout(host_rx_data),
        .full(rx_full), .empty(rx_empty), .count(rx_count)
    );

    always_ff @(posedge clk) begin
        if (rst || !tx_en)             last_word <= '0;
        else if (shf_load && !tx_empty) last_word <= tx_head;
    end
    assign shf_tx_data = last_word;

    always_comb begin
        ev.tx_ovf = tx_en && host_tx_wr && tx_full;
        ev.tx_udf = tx_en && shf_load && tx_empty;
        ev.rx_udf = rx_en && host_rx_rd && rx_empty;
    end

    sfifo_err_flags u_flags (
        .clk(clk), .rst(rst), .ev(ev),
        .clr_we(host_stat_wr), .clr_mask(err_flags_t'(host_stat_wdata)),
        .flags(flags_q)
    );
    assign stat_flags = flags_q;

    // R4
    repeat_word_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_en && shf_load && tx_empty) |=> $stable(shf_tx_data));

    // R6
    tx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !stat_flags[2] && !stat_flags[1]) |=> (!stat_flags[2] && !stat_flags[1]));

    // R6
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !stat_flags[0]) |=> !stat_flags[0]);

    // R9
    tx_off_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (shf_tx_data == '0));

endmodule

// File: tb/test_audio_fifo_ctrl.sv
module test_audio_fifo_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int W     = 32;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          tx_en, rx_en;
    logic          host_tx_wr, host_rx_rd, host_stat_wr;
    logic [W-1:0]  host_tx_data, host_rx_data;
    logic [2:0]    host_stat_wdata, stat_flags;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0] tx_count, rx_count;
    logic          shf_load, shf_rx_push;
    logic [W-1:0]  shf_tx_data, shf_rx_data;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] txq[$];
    logic [W-1:0] rxq[$];
    logic [W-1:0] m_last;
    logic [2:0]   m_flags;

    always #(CLK_PERIOD / 2) clk = ~clk;

    audio_fifo_ctrl #(.W(W), .DEPTH(DEPTH)) i_audio_fifo_ctrl (
        .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en),
        .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
        .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
        .host_stat_wr(host_stat_wr), .host_stat_wdata(host_stat_wdata),
        .stat_flags(stat_flags),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_count(tx_count),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_count(rx_count),
        .shf_load(shf_load), .shf_tx_data(shf_tx_data),
        .shf_rx_push(shf_rx_push), .shf_rx_data(shf_rx_data)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1/R3/R9/R10 tx_count", W'(tx_count), W'(txq.size()));
        chk("R1 tx_full",  W'(tx_full),  W'(txq.size() == DEPTH));
        chk("R1 tx_empty", W'(tx_empty), W'(txq.size() == 0));
        chk("R1/R9/R10/R11 rx_count", W'(rx_count), W'(rxq.size()));
        chk("R1 rx_full",  W'(rx_full),  W'(rxq.size() == DEPTH));
        chk("R1 rx_empty", W'(rx_empty), W'(rxq.size() == 0));
        chk("R3/R6/R7/R8 tx overflow flag",  W'(stat_flags[2]), W'(m_flags[2]));
        chk("R4/R6/R7/R8 tx underflow flag", W'(stat_flags[1]), W'(m_flags[1]));
        chk("R5/R6/R7/R8/R11 rx underflow flag", W'(stat_flags[0]), W'(m_flags[0]));
        chk("R2/R4/R9 shf_tx_data", shf_tx_data, m_last);
        if (rxq.size() > 0) chk("R2 host_rx_data", host_rx_data, rxq[0]);
    endtask

    task automatic model_step();
        int  ts = txq.size();
        int  rs = rxq.size();
        logic [2:0] ev = 3'b000;
        logic [W-1:0] tmp;
        if (!tx_en) begin
            txq.delete();
            m_last = '0;
        end else begin
            if (host_tx_wr && ts == DEPTH) ev[2] = 1'b1;
            if (shf_load && ts == 0) ev[1] = 1'b1;
            if (shf_load && ts > 0) m_last = txq.pop_front();
            if (host_tx_wr && ts < DEPTH) txq.push_back(host_tx_data);
        end
        if (!rx_en) begin
            rxq.delete();
        end else begin
            if (host_rx_rd && rs == 0) ev[0] = 1'b1;
            if (host_rx_rd && rs > 0) tmp = rxq.pop_front();
            if (shf_rx_push && rs < DEPTH) rxq.push_back(shf_rx_data);
        end
        m_flags = (m_flags & ~(host_stat_wr ? host_stat_wdata : 3'b000)) | ev;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int pw, pl, ps, pr, poff, pclr;
        rst = 1'b1; tx_en = 1'b0; rx_en = 1'b0;
        host_tx_wr = 1'b0; host_rx_rd = 1'b0; host_stat_wr = 1'b0;
        host_tx_data = '0; host_stat_wdata = '0;
        shf_load = 1'b0; shf_rx_push = 1'b0; shf_rx_data = '0;
        txq.delete(); rxq.delete(); m_last = '0; m_flags = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        compare_all();
        rst = 1'b0; tx_en = 1'b1; rx_en = 1'b1;
        for (int ph = 0; ph < 12; ph++) begin
            case (ph % 4)
                0: begin pw = 85; pl = 10; ps = 85; pr = 10; end
                1: begin pw = 10; pl = 80; ps = 10; pr = 80; end
                2: begin pw = 50; pl = 50; ps = 50; pr = 50; end
                default: begin pw = 70; pl = 60; ps = 60; pr = 70; end
            endcase
            poff = (ph < 4) ? 0 : 4;
            pclr = (ph % 3 == 0) ? 5 : 25;
            for (int c = 0; c < 300; c++) begin
                @(negedge clk);
                compare_all();
                host_tx_wr      = ($urandom % 100) < pw;
                host_tx_data    = $urandom;
                shf_load        = ($urandom % 100) < pl;
                shf_rx_push     = ($urandom % 100) < ps;
                shf_rx_data     = $urandom;
                host_rx_rd      = ($urandom % 100) < pr;
                host_stat_wr    = ($urandom % 100) < pclr;
                host_stat_wdata = 3'($urandom);
                tx_en           = !(($urandom % 100) < poff);
                rx_en           = !(($urandom % 100) < poff);
                model_step();
            end
        end
        @(negedge clk);
        compare_all();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule